// File: doc/BRIEF.md
# RTC Status Flag and Multifunction Pin Controller

This block keeps the status and control bits of a real-time clock. It holds the oscillator-failure flag and its interrupt, the low-battery flag with its scheduled checks, the century bit and its enable, and the control bits that select what the shared open-drain output pin shows. Timekeeping, the serial host bus, alarm matching, the watchdog timer, square-wave generation and the analog comparator live elsewhere. Those blocks feed this one with a seconds tick, an oscillator-running level, a comparator result, a supply-good level, a century-rollover pulse, power-up pulses and the test and square waveforms.

Software writes registers through a simple write port that carries a 2-bit select and a data byte. The current contents can be read at any time on dedicated read buses. The pin output is an active-low drive enable: when `pin_pull_lo` is 1, the external open-drain pin is pulled low.

Top module: `rtc_flag_ctrl`

## Requirements
- R1: When the century enable (century register bit 0) is 1, a `cent_roll` pulse inverts the century bit (century register bit 1). When the enable is 0, the century bit keeps its value. The century read bus is {century bit, enable}.
- R2: The oscillator-fail flag (flag read bit 0) is forced to 1 by `por_first`, by `osc_run` low, and by the stop bit (control bit 0) being 1. Nothing but a software clear returns it to 0.
- R3: Writing the flag register (select 3) with data bit 0 at 0 clears the oscillator-fail flag only after `osc_run` has stayed high through at least SETTLE_SEC seconds ticks since it last rose. Before that, the flag stays 1. A low on `osc_run` restarts that count.
- R4: `irq_out` is 1 exactly when the interrupt enable (control bit 7) and the oscillator-fail flag are both 1. It falls only when one of them is written to 0.
- R5: A battery check runs on each power-up pulse and every DAY_SEC seconds ticks, but only while `supply_ok` is 1. At a check, the low-battery flag (flag read bit 1) takes the value of `batt_below`. Between checks the flag holds.
- R6: The seconds count toward the next scheduled check restarts at every power-up pulse and does not advance while `supply_ok` is 0.
- R7: The pin drive is chosen by a fixed priority. An asserted interrupt pulls the pin low. Otherwise, when frequency test (control bit 3) is on, the drive follows `ftest_wave` inverted. Otherwise, when square-wave enable (control bit 6) is on, it follows `sqw_wave` inverted. Otherwise, when alarm enable (control bit 4) is on or the watchdog register is nonzero, the pin is released. In every other case the pin is pulled low exactly when OUT (control bit 2) is 0.
- R8: Reset and `por_first` load the control register with 0x07 (stop, halt-update and OUT set; frequency test, alarm enable, alarm-in-battery enable, square-wave enable and interrupt enable clear), clear the watchdog register, and set the oscillator-fail flag.
- R9: `por_next` sets halt-update (control bit 1) and clears frequency test and the watchdog register. Every other control bit keeps its value.
- R10: While `supply_ok` is 0, writes to any register (select 0 control, 1 century, 2 watchdog, 3 flag) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 century, 2 watchdog, 3 flag |
| wr_data | input | DATA_W | Write data |
| sec_tick | input | 1 | One-cycle pulse per second |
| osc_run | input | 1 | Oscillator running indication |
| batt_below | input | 1 | Battery comparator result, 1 = below threshold |
| supply_ok | input | 1 | Main supply good |
| cent_roll | input | 1 | Century rollover pulse |
| por_first | input | 1 | First power-up pulse |
| por_next | input | 1 | Later power-up pulse with battery backup |
| ftest_wave | input | 1 | Frequency test waveform |
| sqw_wave | input | 1 | Square-wave waveform |
| ctrl_rd | output | 8 | Control register contents |
| cent_rd | output | 2 | {century bit, century enable} |
| wdog_rd | output | DATA_W | Watchdog register contents |
| flag_rd | output | 2 | {battery low, oscillator fail} |
| irq_out | output | 1 | Oscillator-fail interrupt |
| pin_pull_lo | output | 1 | Pin drive enable, 1 pulls the pin low |

## Verification
The pin selection is swept over all 256 combinations of interrupt enable, frequency test, square-wave enable, alarm enable, OUT, watchdog zero or nonzero, and the two waveform levels, with the oscillator flag held set. This separates each priority level from the ones below it and shows that the waveforms pass inverted. The century logic is tried in all four enable and bit combinations, which separates toggling from holding. The oscillator clear is attempted one tick short of the settle time and then at the settle time, both after a clean start and after a dropout, which shows whether the count restarts. The battery schedule is run one tick short of the interval and then at it, with a supply outage in between, to tell a paused count from a running one.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CENT = 2'd1,
        SEL_WDOG = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic ofie;
        logic sqw_en;
        logic alarm_batt_en;
        logic alarm_en;
        logic ftest;
        logic out_lvl;
        logic halt_upd;
        logic stop;
    } ctrl_t;

    localparam ctrl_t CTRL_FIRST_DEF = '{
        ofie: 1'b0, sqw_en: 1'b0, alarm_batt_en: 1'b0, alarm_en: 1'b0,
        ftest: 1'b0, out_lvl: 1'b1, halt_upd: 1'b1, stop: 1'b1
    };

endpackage

// File: rtl/rtc_osc_mon.sv
module rtc_osc_mon #(
    parameter int SETTLE_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_first,
    input  logic osc_run,
    input  logic sec_tick,
    input  logic stop_bit,
    input  logic clr_req,
    output logic osc_fail
);
    localparam int CW = $clog2(SETTLE_SEC + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(SETTLE_SEC);

    typedef struct packed {
        logic [CW-1:0] run_cnt;
        logic          fail;
    } osc_st_t;

    osc_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!osc_run) begin
            s_d.run_cnt = '0;
        end else if (sec_tick && s_q.run_cnt != CNT_DONE) begin
            s_d.run_cnt = s_q.run_cnt + 1'b1;
        end
        if (clr_req && s_q.run_cnt == CNT_DONE) begin
            s_d.fail = 1'b0;
        end
        if (por_first || !osc_run || stop_bit) begin
            s_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{run_cnt: '0, fail: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign osc_fail = s_q.fail;

    AST_OSCF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run || stop_bit || por_first) |=> s_q.fail); // R2
    AST_OSCF_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fail && s_q.run_cnt != CNT_DONE) |=> s_q.fail); // R3
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> (s_q.run_cnt == '0)); // R3
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run_cnt <= CNT_DONE); // R3

endmodule

// File: rtl/rtc_batt_sched.sv
module rtc_batt_sched #(
    parameter int DAY_SEC = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_any,
    input  logic supply_ok,
    input  logic sec_tick,
    input  logic batt_below,
    output logic batt_low
);
    localparam int DW = $clog2(DAY_SEC);
    localparam logic [DW-1:0] DAY_LAST = DW'(DAY_SEC - 1);

    typedef struct packed {
        logic [DW-1:0] day_cnt;
        logic          low;
    } bat_st_t;

    bat_st_t s_d, s_q;
    logic    chk_now;

    always_comb begin
        s_d     = s_q;
        chk_now = supply_ok && (por_any || (sec_tick && s_q.day_cnt == DAY_LAST));
        if (por_any) begin
            s_d.day_cnt = '0;
        end else if (supply_ok && sec_tick) begin
            s_d.day_cnt = (s_q.day_cnt == DAY_LAST) ? '0 : s_q.day_cnt + 1'b1;
        end
        if (chk_now) begin
            s_d.low = batt_below;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{day_cnt: '0, low: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign batt_low = s_q.low;

    AST_BL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || (!por_any && !sec_tick)) |=> $stable(s_q.low)); // R5
    AST_DAY_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !por_any) |=> $stable(s_q.day_cnt)); // R6
    AST_DAY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        por_any |=> (s_q.day_cnt == '0)); // R6

endmodule

// File: rtl/rtc_pin_sel.sv
module rtc_pin_sel (
    input  logic irq,
    input  logic ftest,
    input  logic ftest_wave,
    input  logic sqw_en,
    input  logic sqw_wave,
    input  logic alarm_en,
    input  logic wdog_on,
    input  logic out_lvl,
    output logic pull_lo
);
    always_comb begin
        if (irq) begin
            pull_lo = 1'b1;
        end else if (ftest) begin
            pull_lo = ~ftest_wave;
        end else if (sqw_en) begin
            pull_lo = ~sqw_wave;
        end else if (alarm_en || wdog_on) begin
            pull_lo = 1'b0;
        end else begin
            pull_lo = ~out_lvl;
        end
    end
endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
    import rtc_flag_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SETTLE_SEC = 4,
    parameter int DAY_SEC    = 86400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sec_tick,
    input  logic              osc_run,
    input  logic              batt_below,
    input  logic              supply_ok,
    input  logic              cent_roll,
    input  logic              por_first,
    input  logic              por_next,
    input  logic              ftest_wave,
    input  logic              sqw_wave,
    output logic [7:0]        ctrl_rd,
    output logic [1:0]        cent_rd,
    output logic [DATA_W-1:0] wdog_rd,
    output logic [1:0]        flag_rd,
    output logic              irq_out,
    output logic              pin_pull_lo
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              cent_en;
        logic              cent_bit;
        logic [DATA_W-1:0] wdog;
    } top_st_t;

    top_st_t  r_d, r_q;
    reg_sel_e sel;
    logic     wr_ok;
    logic     clr_req;
    logic     osc_fail;
    logic     batt_low;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_ok   = wr_en && supply_ok;
    assign clr_req = wr_ok && (sel == SEL_FLAG) && !wr_data[0];

    always_comb begin
        r_d = r_q;
        if (wr_ok && sel == SEL_CTRL) begin
            r_d.ctrl = ctrl_t'(wr_data[7:0]);
        end
        if (wr_ok && sel == SEL_WDOG) begin
            r_d.wdog = wr_data;
        end
        if (wr_ok && sel == SEL_CENT) begin
            r_d.cent_en  = wr_data[0];
            r_d.cent_bit = wr_data[1];
        end else if (cent_roll && r_q.cent_en) begin
            r_d.cent_bit = ~r_q.cent_bit;
        end
        if (por_next) begin
            r_d.ctrl.halt_upd = 1'b1;
            r_d.ctrl.ftest    = 1'b0;
            r_d.wdog          = '0;
        end
        if (por_first) begin
            r_d.ctrl = CTRL_FIRST_DEF;
            r_d.wdog = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ctrl: CTRL_FIRST_DEF, cent_en: 1'b0, cent_bit: 1'b0, wdog: '0};
        end else begin
            r_q <= r_d;
        end
    end

    rtc_osc_mon #(.SETTLE_SEC(SETTLE_SEC)) u_osc (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_first(por_first),
        .osc_run  (osc_run),
        .sec_tick (sec_tick),
        .stop_bit (r_q.ctrl.stop),
        .clr_req  (clr_req),
        .osc_fail (osc_fail)
    );

    rtc_batt_sched #(.DAY_SEC(DAY_SEC)) u_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_any   (por_first || por_next),
        .supply_ok (supply_ok),
        .sec_tick  (sec_tick),
        .batt_below(batt_below),
        .batt_low  (batt_low)
    );

    assign irq_out = r_q.ctrl.ofie && osc_fail;

    rtc_pin_sel u_pin (
        .irq       (irq_out),
        .ftest     (r_q.ctrl.ftest),
        .ftest_wave(ftest_wave),
        .sqw_en    (r_q.ctrl.sqw_en),
        .sqw_wave  (sqw_wave),
        .alarm_en  (r_q.ctrl.alarm_en),
        .wdog_on   (|r_q.wdog),
        .out_lvl   (r_q.ctrl.out_lvl),
        .pull_lo   (pin_pull_lo)
    );

    assign ctrl_rd = r_q.ctrl;
    assign cent_rd = {r_q.cent_bit, r_q.cent_en};
    assign wdog_rd = r_q.wdog;
    assign flag_rd = {batt_low, osc_fail};

    AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.cent_en && !(wr_ok && sel == SEL_CENT)) |=> $stable(r_q.cent_bit)); // R1
    AST_IRQ_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pin_pull_lo); // R7
    AST_IRQ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !wr_en && !por_first) |=> irq_out); // R4
    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !por_first && !por_next) |=> ($stable(r_q.ctrl) && $stable(r_q.wdog))); // R10
    AST_FIRST_DEF: assert property (@(posedge clk) disable iff (!rst_n)
        por_first |=> (ctrl_rd == 8'h07 && wdog_rd == '0 && flag_rd[0])); // R8
    AST_NEXT_DEF: assert property (@(posedge clk) disable iff (!rst_n)
        (por_next && !por_first) |=> (ctrl_rd[1] && !ctrl_rd[3] && wdog_rd == '0)); // R9

endmodule

// File: tb/rtc_flag_ctrl_tb.sv
module rtc_flag_ctrl_tb;
    localparam int DAY = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       sec_tick = 1'b0;
    logic       osc_run = 1'b0;
    logic       batt_below = 1'b0;
    logic       supply_ok = 1'b1;
    logic       cent_roll = 1'b0;
    logic       por_first = 1'b0;
    logic       por_next = 1'b0;
    logic       ftest_wave = 1'b0;
    logic       sqw_wave = 1'b0;
    logic [7:0] ctrl_rd;
    logic [1:0] cent_rd;
    logic [7:0] wdog_rd;
    logic [1:0] flag_rd;
    logic       irq_out;
    logic       pin_pull_lo;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rtc_flag_ctrl #(.DATA_W(8), .SETTLE_SEC(4), .DAY_SEC(DAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_tick(sec_tick), .osc_run(osc_run), .batt_below(batt_below),
        .supply_ok(supply_ok), .cent_roll(cent_roll), .por_first(por_first),
        .por_next(por_next), .ftest_wave(ftest_wave), .sqw_wave(sqw_wave),
        .ctrl_rd(ctrl_rd), .cent_rd(cent_rd), .wdog_rd(wdog_rd), .flag_rd(flag_rd),
        .irq_out(irq_out), .pin_pull_lo(pin_pull_lo)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1;
            cyc();
            sec_tick = 1'b0;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R8 reset state
        chk("R8 reset ctrl", ctrl_rd, 8'h07);
        chk("R8 reset wdog", wdog_rd, 8'h00);
        chk("R8 reset oscfail", flag_rd[0], 1'b1);
        chk("R7 reset pin follows OUT=1", pin_pull_lo, 1'b0);

        // R3 settle window
        wr(2'd0, 8'h00);
        chk("R7 OUT=0 pulls low", pin_pull_lo, 1'b1);
        osc_run = 1'b1;
        cyc();
        ticks(3);
        wr(2'd3, 8'h00);
        chk("R3 clear too early", flag_rd[0], 1'b1);
        ticks(1);
        wr(2'd3, 8'h00);
        chk("R3 clear after settle", flag_rd[0], 1'b0);
        osc_run = 1'b0;
        cyc();
        osc_run = 1'b1;
        chk("R2 osc stop sets flag", flag_rd[0], 1'b1);
        ticks(2);
        wr(2'd3, 8'h00);
        chk("R3 restart count after drop", flag_rd[0], 1'b1);
        ticks(2);
        wr(2'd3, 8'h00);
        chk("R3 clear after restart settle", flag_rd[0], 1'b0);
        wr(2'd0, 8'h01);
        cyc();
        chk("R2 stop bit sets flag", flag_rd[0], 1'b1);
        wr(2'd0, 8'h00);
        ticks(4);
        wr(2'd3, 8'h00);
        chk("R3 clear after stop released", flag_rd[0], 1'b0);

        // R4 interrupt
        wr(2'd0, 8'h80);
        chk("R4 enable alone", irq_out, 1'b0);
        osc_run = 1'b0;
        cyc();
        osc_run = 1'b1;
        chk("R4 both set", irq_out, 1'b1);
        chk("R7 irq pulls low", pin_pull_lo, 1'b1);
        ticks(4);
        chk("R4 irq sticky", irq_out, 1'b1);
        wr(2'd3, 8'h00);
        chk("R4 cleared by flag", irq_out, 1'b0);
        osc_run = 1'b0;
        cyc();
        osc_run = 1'b1;
        chk("R4 reasserted", irq_out, 1'b1);
        wr(2'd0, 8'h00);
        chk("R4 cleared by enable", irq_out, 1'b0);

        // R10 writes ignored without supply
        ticks(4);
        supply_ok = 1'b0;
        wr(2'd0, 8'hFF);
        chk("R10 ctrl ignored", ctrl_rd, 8'h00);
        wr(2'd2, 8'h05);
        chk("R10 wdog ignored", wdog_rd, 8'h00);
        wr(2'd1, 8'h03);
        chk("R10 cent ignored", cent_rd, 2'b00);
        wr(2'd3, 8'h00);
        chk("R10 flag clear ignored", flag_rd[0], 1'b1);
        supply_ok = 1'b1;
        cyc();

        // R1 century
        for (int v = 0; v < 4; v++) begin
            wr(2'd1, 8'(v));
            cent_roll = 1'b1;
            cyc();
            cent_roll = 1'b0;
            chk("R1 century roll", cent_rd, {v[1] ^ v[0], v[0]});
        end

        // R7 exhaustive pin sweep, oscillator flag held set
        osc_run = 1'b0;
        cyc();
        for (int v = 0; v < 256; v++) begin
            logic ofie, ft, sq, al, ol, wn, fw, sw, exp;
            ofie = v[0]; ft = v[1]; sq = v[2]; al = v[3];
            ol = v[4]; wn = v[5]; fw = v[6]; sw = v[7];
            wr(2'd0, {ofie, sq, 1'b0, al, ft, ol, 2'b00});
            wr(2'd2, wn ? 8'h3C : 8'h00);
            ftest_wave = fw;
            sqw_wave = sw;
            #1;
            if (ofie) exp = 1'b1;
            else if (ft) exp = ~fw;
            else if (sq) exp = ~sw;
            else if (al || wn) exp = 1'b0;
            else exp = ~ol;
            chk("R7 pin priority", pin_pull_lo, exp);
            chk("R4 irq in sweep", irq_out, ofie);
        end
        osc_run = 1'b1;

        // R9 later power-up, R5 check at power-up
        wr(2'd0, 8'hF8);
        wr(2'd2, 8'h5A);
        batt_below = 1'b1;
        por_next = 1'b1;
        cyc();
        por_next = 1'b0;
        chk("R9 ctrl after later power-up", ctrl_rd, 8'hF2);
        chk("R9 wdog cleared", wdog_rd, 8'h00);
        chk("R5 check at power-up", flag_rd[1], 1'b1);
        batt_below = 1'b0;
        ticks(DAY - 1);
        chk("R5 flag holds between checks", flag_rd[1], 1'b1);
        ticks(1);
        chk("R5 scheduled check clears", flag_rd[1], 1'b0);
        ticks(4);
        supply_ok = 1'b0;
        ticks(20);
        supply_ok = 1'b1;
        batt_below = 1'b1;
        ticks(5);
        chk("R6 count paused while supply bad", flag_rd[1], 1'b0);
        ticks(1);
        chk("R6 check after paused interval", flag_rd[1], 1'b1);

        // R8 first power-up
        batt_below = 1'b0;
        wr(2'd2, 8'h11);
        por_first = 1'b1;
        cyc();
        por_first = 1'b0;
        chk("R8 ctrl defaults", ctrl_rd, 8'h07);
        chk("R8 wdog default", wdog_rd, 8'h00);
        chk("R8 oscfail set", flag_rd[0], 1'b1);
        chk("R5 first power-up check", flag_rd[1], 1'b0);

        done = 1'b1;
        report();
    end
endmodule